// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces an I2C Repeated Start on the open-drain SDA and SCL lines when a bus master sits between two transfers. It contains its own down-counting baud timer. Firmware-style inputs request the sequence, supply the timer reload value and write the transmit buffer. The sequencer drives the two lines through drive-low enables and watches the sampled pin levels. Each timed phase starts only once the pin level it depends on has actually been seen, so a slave that stretches the clock or holds data only lengthens the sequence.

While the sequence runs, new control requests are locked out and writes to the transmit buffer are refused and flagged. Two bus-collision cases are detected. On either one the block releases both lines, drops the enable and returns to idle. A pin monitor flags any start pattern on the wires. An interrupt flag marks the normal end of the sequence. The four status flags are sticky until a clear strobe.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset both drive-low enables, the enable bit, all four flags and the transmit buffer are 0.
- R2: A control write with the request bit set, while the sequencer is idle and `other_busy` is low, sets `rs_en` and drives SCL low from the next cycle.
- R3: Let N be `reload`. Once SCL is sampled low, SDA is released and SCL stays driven low for N cycles. The sequencer then keeps SCL low until SDA is sampled high, which adds at least one cycle.
- R4: SCL is released only after SDA has been sampled high. An external device holding SDA low keeps SCL driven low for as long as it holds it.
- R5: After SCL is released, the sequencer waits for SCL to be sampled high and then keeps both lines released for N cycles. It then drives SDA low for N cycles while leaving SCL released. At the end it clears `rs_en` and keeps SDA driven low while idle, up to the next accepted request.
- R6: A request made while `other_busy` is high has no effect. Any control write made while the sequence runs leaves `rs_en` unchanged, whatever its request bit.
- R7: `start_seen` sets one cycle after the pins show SDA going from high to low while SCL is high.
- R8: `irq` sets in the same cycle that `rs_en` clears at the normal end of the sequence.
- R9: A transmit-buffer write while idle loads `tx_buf`. A write while the sequence runs sets `wcol` and leaves `tx_buf` unchanged.
- R10: A bus collision sets `bcol`, releases both lines, clears `rs_en` and returns to idle. Two cases count as a collision:
  - SDA is low when SCL is first sampled high after the sequencer released it.
  - SCL is sampled low during the phase in which both lines must stay high.
- R11: `flags_clr` clears `start_seen`, `irq`, `wcol` and `bcol`. A flag being set in the same cycle wins over the clear.
- R12: A reload value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_rs | input | 1 | Request bit carried by the control write |
| other_busy | input | 1 | Another bus event is in progress |
| reload | input | CNT_W | Baud timer reload value N |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| txbuf_wdata | input | BUF_W | Transmit-buffer write data |
| flags_clr | input | 1 | Clears the four status flags |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| sda_drive_low | output | 1 | Pull SDA low |
| scl_drive_low | output | 1 | Pull SCL low |
| rs_en | output | 1 | Enable bit, self-clearing |
| start_seen | output | 1 | Start pattern seen on the pins |
| irq | output | 1 | Sequence completed |
| wcol | output | 1 | Write collision |
| bcol | output | 1 | Bus collision |
| tx_buf | output | BUF_W | Transmit buffer contents |

## Verification
The bench holds SDA low from outside after the timed release. A design that released SCL on the timer alone would then raise the clock with data low. It also stretches SCL and then pulls it low mid-phase, where a design that timed from its own release, or missed the collision, would finish the sequence instead of aborting. Other cases target a buffer write or a second request during the sequence, a zero reload, and a request while another event is busy. A design that queued the request, overwrote the buffer or spun its counter forever would diverge from the cycle model at once.

// File: rtl/rstart_pkg.sv
package rstart_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCL_LOW,
        PH_SDA_REL,
        PH_SDA_CHK,
        PH_SCL_WAIT,
        PH_BOTH_HI,
        PH_SDA_LOW
    } rs_phase_e;

    typedef struct packed {
        logic sda_low;
        logic scl_low;
    } line_drive_t;

    // Line drive pattern for a phase; hold keeps SDA low after completion.
    function automatic line_drive_t phase_drive(input rs_phase_e ph, input logic hold);
        line_drive_t d;
        d.scl_low = (ph == PH_SCL_LOW) || (ph == PH_SDA_REL) || (ph == PH_SDA_CHK);
        d.sda_low = (ph == PH_SDA_LOW) || (hold && ((ph == PH_IDLE) || (ph == PH_SCL_LOW)));
        return d;
    endfunction

endpackage

// File: rtl/rsg_brg.sv
module rsg_brg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             tmo
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= (reload == '0) ? ONE : reload;
        else if (cnt != '0)
            cnt <= cnt - ONE;
    end

    assign tmo = (cnt == ONE);

    AST_TMO_THEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tmo && !load) |=> (cnt == '0)); // R3
    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt != '0)); // R12
endmodule

// File: rtl/rsg_pinmon.sv
module rsg_pinmon (
    input  logic clk,
    input  logic rst,
    input  logic sda_in,
    input  logic scl_in,
    input  logic flags_clr,
    output logic start_seen
);
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_prev   <= 1'b1;
            start_seen <= 1'b0;
        end else begin
            sda_prev <= sda_in;
            if (sda_prev && !sda_in && scl_in)
                start_seen <= 1'b1;
            else if (flags_clr)
                start_seen <= 1'b0;
        end
    end

    AST_START_SETS: assert property (@(posedge clk) disable iff (rst)
        ($past(sda_in) && !sda_in && scl_in) |=> start_seen); // R7
endmodule

// File: rtl/rsg_seq.sv
module rsg_seq
    import rstart_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic        ctrl_rs,
    input  logic        other_busy,
    input  logic        sda_in,
    input  logic        scl_in,
    input  logic        tmo,
    input  logic        flags_clr,
    output logic        load,
    output logic        busy,
    output line_drive_t drv,
    output logic        rs_en,
    output logic        irq,
    output logic        bcol
);
    rs_phase_e ph, ph_n;
    logic      hold, hold_n, en_n, irq_set, bcol_set, abort;

    always_comb begin
        ph_n     = ph;
        hold_n   = hold;
        en_n     = rs_en;
        load     = 1'b0;
        irq_set  = 1'b0;
        abort    = 1'b0;
        case (ph)
            PH_IDLE:
                if (ctrl_wr && ctrl_rs && !other_busy) begin
                    ph_n = PH_SCL_LOW;
                    en_n = 1'b1;
                end
            PH_SCL_LOW:
                if (!scl_in) begin
                    ph_n   = PH_SDA_REL;
                    load   = 1'b1;
                    hold_n = 1'b0;
                end
            PH_SDA_REL:
                if (tmo) ph_n = PH_SDA_CHK;
            PH_SDA_CHK:
                if (sda_in) ph_n = PH_SCL_WAIT;
            PH_SCL_WAIT:
                if (scl_in) begin
                    if (!sda_in) abort = 1'b1;
                    else begin
                        ph_n = PH_BOTH_HI;
                        load = 1'b1;
                    end
                end
            PH_BOTH_HI:
                if (!scl_in) abort = 1'b1;
                else if (tmo) begin
                    ph_n = PH_SDA_LOW;
                    load = 1'b1;
                end
            PH_SDA_LOW:
                if (tmo) begin
                    ph_n    = PH_IDLE;
                    en_n    = 1'b0;
                    hold_n  = 1'b1;
                    irq_set = 1'b1;
                end
            default: ph_n = PH_IDLE;
        endcase
        if (abort) begin
            ph_n   = PH_IDLE;
            en_n   = 1'b0;
            hold_n = 1'b0;
            load   = 1'b0;
        end
        bcol_set = abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            hold  <= 1'b0;
            rs_en <= 1'b0;
            irq   <= 1'b0;
            bcol  <= 1'b0;
        end else begin
            ph    <= ph_n;
            hold  <= hold_n;
            rs_en <= en_n;
            irq   <= irq_set  ? 1'b1 : (flags_clr ? 1'b0 : irq);
            bcol  <= bcol_set ? 1'b1 : (flags_clr ? 1'b0 : bcol);
        end
    end

    assign drv  = phase_drive(ph, hold);
    assign busy = (ph != PH_IDLE);

    AST_NO_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && ctrl_wr && ctrl_rs && other_busy) |=> (ph == PH_IDLE)); // R6
    AST_SCL_RELEASE_NEEDS_SDA: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.scl_low) |-> $past(sda_in)); // R4
    AST_BCOL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol) |-> (!drv.sda_low && !drv.scl_low && !rs_en)); // R10
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (!rs_en && drv.sda_low && $past(scl_in))); // R8
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
    import rstart_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BUF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             ctrl_rs,
    input  logic             other_busy,
    input  logic [CNT_W-1:0] reload,
    input  logic             txbuf_wr,
    input  logic [BUF_W-1:0] txbuf_wdata,
    input  logic             flags_clr,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_drive_low,
    output logic             scl_drive_low,
    output logic             rs_en,
    output logic             start_seen,
    output logic             irq,
    output logic             wcol,
    output logic             bcol,
    output logic [BUF_W-1:0] tx_buf
);
    logic        load, tmo, busy;
    line_drive_t drv;

    rsg_brg #(.CNT_W(CNT_W)) brg_i (
        .clk(clk), .rst(rst), .load(load), .reload(reload), .tmo(tmo)
    );

    rsg_seq seq_i (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rs(ctrl_rs),
        .other_busy(other_busy), .sda_in(sda_in), .scl_in(scl_in), .tmo(tmo),
        .flags_clr(flags_clr), .load(load), .busy(busy), .drv(drv),
        .rs_en(rs_en), .irq(irq), .bcol(bcol)
    );

    rsg_pinmon pinmon_i (
        .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
        .flags_clr(flags_clr), .start_seen(start_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf <= '0;
            wcol   <= 1'b0;
        end else begin
            if (txbuf_wr && !busy) tx_buf <= txbuf_wdata;
            if (txbuf_wr && busy)  wcol   <= 1'b1;
            else if (flags_clr)    wcol   <= 1'b0;
        end
    end

    assign sda_drive_low = drv.sda_low;
    assign scl_drive_low = drv.scl_low;

    AST_WCOL_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
        (txbuf_wr && busy) |=> (wcol && $stable(tx_buf))); // R9
endmodule

// File: tb/i2c_rstart_gen_tb.sv
module i2c_rstart_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 0, ctrl_rs = 0, other_busy = 0, txbuf_wr = 0, flags_clr = 0;
    logic [7:0] reload = 8'd3, txbuf_wdata = 8'd0;
    logic       ext_sda_low = 0, ext_scl_low = 0;
    logic       sda_in, scl_in;
    logic       sda_drive_low, scl_drive_low, rs_en, start_seen, irq, wcol, bcol;
    logic [7:0] tx_buf;

    integer checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_in = !(sda_drive_low || ext_sda_low);
    assign scl_in = !(scl_drive_low || ext_scl_low);

    i2c_rstart_gen dut_i (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_rs(ctrl_rs), .other_busy(other_busy),
        .reload(reload), .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata), .flags_clr(flags_clr),
        .sda_in(sda_in), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
        .scl_drive_low(scl_drive_low), .rs_en(rs_en), .start_seen(start_seen), .irq(irq),
        .wcol(wcol), .bcol(bcol), .tx_buf(tx_buf)
    );

    task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase number and remaining cycles.
    integer mph = 0, mrem = 0, mn;
    bit m_hold, m_en, m_irq, m_bcol, m_wcol, m_start, m_prev, irq_s, bcol_s, st_s, wc_s;
    logic [7:0] m_buf;

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mrem = 0; m_hold = 0; m_en = 0; m_irq = 0; m_bcol = 0;
            m_wcol = 0; m_start = 0; m_prev = 1; m_buf = 0;
        end else begin
            mn = (reload == 0) ? 1 : reload;
            irq_s = 0; bcol_s = 0;
            st_s = m_prev && !sda_in && scl_in;
            m_prev = sda_in;
            wc_s = txbuf_wr && (mph != 0);
            if (txbuf_wr && mph == 0) m_buf = txbuf_wdata;
            case (mph)
                0: if (ctrl_wr && ctrl_rs && !other_busy) begin mph = 1; m_en = 1; end
                1: if (!scl_in) begin mph = 2; mrem = mn; m_hold = 0; end
                2: begin mrem--; if (mrem == 0) mph = 3; end
                3: if (sda_in) mph = 4;
                4: if (scl_in) begin
                       if (!sda_in) bcol_s = 1;
                       else begin mph = 5; mrem = mn; end
                   end
                5: if (!scl_in) bcol_s = 1;
                   else begin mrem--; if (mrem == 0) begin mph = 6; mrem = mn; end end
                6: begin mrem--; if (mrem == 0) begin mph = 0; m_en = 0; m_hold = 1; irq_s = 1; end end
                default: mph = 0;
            endcase
            if (bcol_s) begin mph = 0; m_en = 0; m_hold = 0; end
            m_irq   = irq_s  | (m_irq   & !flags_clr);
            m_bcol  = bcol_s | (m_bcol  & !flags_clr);
            m_wcol  = wc_s   | (m_wcol  & !flags_clr);
            m_start = st_s   | (m_start & !flags_clr);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(scl_drive_low == (mph >= 1 && mph <= 3), "R2 scl drive", scl_drive_low, (mph >= 1 && mph <= 3));
            chk(sda_drive_low == (mph == 6 || (m_hold && mph <= 1)), "R5 sda drive", sda_drive_low, (mph == 6 || (m_hold && mph <= 1)));
            chk(rs_en == m_en, "R6 rs_en", rs_en, m_en);
            chk(start_seen == m_start, "R7 start_seen", start_seen, m_start);
            chk(irq == m_irq, "R8 irq", irq, m_irq);
            chk(wcol == m_wcol, "R9 wcol", wcol, m_wcol);
            chk(tx_buf == m_buf, "R9 tx_buf", tx_buf, m_buf);
            chk(bcol == m_bcol, "R10 bcol", bcol, m_bcol);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic request();
        @(negedge clk); ctrl_wr = 1; ctrl_rs = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flags_clr = 1;
        @(negedge clk); flags_clr = 0;
    endtask

    // Full sequence on free lines; counts cycles per line pattern.
    task automatic run_plain(input integer n);
        integer rel, both, low;
        bit held_before;
        rel = 0; both = 0; low = 0;
        reload = n[7:0];
        held_before = sda_drive_low;
        @(negedge clk); ctrl_wr = 1; ctrl_rs = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0;
        for (int k = 0; k < 2000 && rs_en; k++) begin
            if (scl_drive_low && !sda_drive_low) rel++;
            if (!scl_drive_low && !sda_drive_low) both++;
            if (sda_drive_low && !scl_drive_low) low++;
            @(negedge clk);
        end
        if (n == 0) n = 1;
        chk(rel == n + (held_before ? 1 : 2), "R3 release phase length", rel, n + (held_before ? 1 : 2));
        chk(both == n + 1, "R5 both-high length", both, n + 1);
        chk(low == n, "R5 sda-low length", low, n);
        chk(irq == 1 && rs_en == 0, "R8 irq at end", irq, 1);
        chk(sda_drive_low == 1 && scl_drive_low == 0, "R5 sda held after end", sda_drive_low, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!sda_drive_low && !scl_drive_low && !rs_en && !irq && !wcol && !bcol && !start_seen && tx_buf == 0,
            "R1 reset state", {sda_drive_low, scl_drive_low, rs_en, irq, wcol, bcol, start_seen}, 0);

        // R9: idle buffer write
        @(negedge clk); txbuf_wr = 1; txbuf_wdata = 8'h3C;
        @(negedge clk); txbuf_wr = 0;
        chk(tx_buf == 8'h3C && !wcol, "R9 idle write", tx_buf, 8'h3C);

        // R6: request while another event busy
        @(negedge clk); other_busy = 1; ctrl_wr = 1; ctrl_rs = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0; other_busy = 0;
        @(negedge clk);
        chk(!rs_en && !scl_drive_low, "R6 busy request ignored", rs_en, 0);

        run_plain(3);
        chk(start_seen == 1, "R7 start seen", start_seen, 1);

        clear_flags();
        chk(!irq && !start_seen && !wcol && !bcol, "R11 flags cleared", {irq, start_seen, wcol, bcol}, 0);

        // R2 / R6 / R9: writes during a running sequence
        reload = 8'd5;
        request();
        chk(rs_en && scl_drive_low, "R2 request accepted", rs_en, 1);
        ctrl_wr = 1; ctrl_rs = 0; txbuf_wr = 1; txbuf_wdata = 8'hA5;
        @(negedge clk); ctrl_wr = 0; txbuf_wr = 0;
        chk(rs_en == 1, "R6 write during sequence ignored", rs_en, 1);
        chk(wcol == 1 && tx_buf == 8'h3C, "R9 write collision keeps buffer", tx_buf, 8'h3C);
        ctrl_wr = 1; ctrl_rs = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0;
        for (int k = 0; k < 200 && rs_en; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!rs_en && !scl_drive_low, "R6 second request not queued", rs_en, 0);

        run_plain(0); // R12

        // R4: external SDA hold stretches the SCL-low phase
        reload = 8'd2;
        @(negedge clk); ctrl_wr = 1; ctrl_rs = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0; ext_sda_low = 1;
        repeat (12) @(negedge clk);
        chk(scl_drive_low == 1, "R4 SCL kept low while SDA held", scl_drive_low, 1);
        ext_sda_low = 0; ext_scl_low = 1;
        for (int k = 0; k < 50 && scl_drive_low; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(rs_en && !sda_drive_low, "R5 waits for SCL high", rs_en, 1);
        ext_scl_low = 0;
        for (int k = 0; k < 200 && rs_en; k++) @(negedge clk);
        chk(irq && !bcol, "R5 stretched sequence completes", irq, 1);

        // R10 case one: SDA low when SCL rises
        clear_flags();
        reload = 8'd3;
        @(negedge clk); ctrl_wr = 1; ctrl_rs = 1; ext_scl_low = 1;
        @(negedge clk); ctrl_wr = 0; ctrl_rs = 0;
        for (int k = 0; k < 50 && scl_drive_low; k++) @(negedge clk);
        ext_sda_low = 1;
        @(negedge clk); ext_scl_low = 0;
        @(negedge clk);
        chk(bcol && !rs_en && !sda_drive_low && !scl_drive_low, "R10 SDA low at SCL rise", bcol, 1);
        ext_sda_low = 0;
        @(negedge clk);

        // R10 case two: SCL pulled low during both-high phase
        clear_flags();
        reload = 8'd4;
        request();
        for (int k = 0; k < 50 && scl_drive_low; k++) @(negedge clk);
        @(negedge clk); ext_scl_low = 1;
        @(negedge clk);
        chk(bcol && !rs_en && !sda_drive_low && !scl_drive_low && !irq, "R10 SCL low before SDA driven", bcol, 1);
        ext_scl_low = 0;
        repeat (3) @(negedge clk);

        // R11: set wins over clear in the same cycle
        @(negedge clk); flags_clr = 1;
        request();
        flags_clr = 0;
        txbuf_wr = 1; flags_clr = 1;
        @(negedge clk); txbuf_wr = 0; flags_clr = 0;
        chk(wcol == 1, "R11 set wins over clear", wcol, 1);
        for (int k = 0; k < 200 && rs_en; k++) @(negedge clk);
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule